// File: doc/BRIEF.md
# Four-Channel Phased PWM Output Controller

This block turns a set of per-channel settings into four output-enable lines for high-side drivers. All four channels share one PWM timebase. The timebase is a 128-step position counter that advances on rising edges of a selectable PWM clock. That clock is either an external pin, which doubles as direct input 0, or an internal clock line. Both clock sources are level signals. They are synchronised into the system clock domain and edge-detected inside the block.

Each channel has an On bit, a 7-bit duty code, a 3-bit phase-delay code and a bit that lets its direct input through. The delay code moves the channel's switching edges later in steps of 16 PWM clocks, so the four loads do not switch together. Duty and delay codes are held in shadow registers that reload only when the counter wraps, so a change never cuts a pulse short. When the global PWM enable is off, the outputs follow the On bits and the permitted direct inputs. When PWM is on but the PWM clock has been reported as failed, the counter stops and each output follows its On bit alone. Every channel also produces a fault-control qualifier that tells the protection logic whether the channel is meant to be driven.

Top module: `pwm_phase_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, the position counter is set to 0, the shadow duty and delay codes are set to 0, and every `out_en` and `fault_qual` bit is 0 on the next edge, whatever the other inputs are.
- R2: With `pwm_en`=1, `clk_fail`=0, On=1 and a shadow delay of 0, a channel whose shadow duty code is n is high at counter positions 0 to n and low at the rest, so code 0 gives 1 of 128 and code 127 gives all 128. The counter counts PWM clock rising edges since reset, modulo 128.
- R3: With `pwm_en`=1 and `clk_fail`=0, a channel whose On bit is 0 keeps `out_en` low at every position and for every duty code.
- R4: A shadow delay code k moves the high window to the positions p for which (p − 16·k) mod 128 ≤ n. Code 0 gives no shift and code 7 gives a shift of 112.
- R5: With `pwm_en`=0, `out_en[x]` = On[x] OR (`din[x]` AND pass[x]).
- R6: `fault_qual[x]` = On[x] OR (`din[x]` AND pass[x] AND NOT `pwm_en`).
- R7: When `clk_sel`=1 the counter advances on rising edges of `din[0]`, and when `clk_sel`=0 it advances on rising edges of `int_clk`. Edges on the source that is not selected do not move the counter.
- R8: While `clk_fail`=1 the counter holds its position. If `pwm_en`=1 as well, `out_en[x]` follows On[x] with no PWM.
- R9: The shadow codes load from `duty_codes` (channel x in bits 7x+6..7x) and `dly_codes` (channel x in bits 3x+2..3x) only on the PWM edge that takes the counter from 127 to 0. After reset the zero codes stay in force until the first wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_en | input | 1 | Global PWM enable |
| clk_sel | input | 1 | PWM clock source: 1 = `din[0]`, 0 = `int_clk` |
| clk_fail | input | 1 | PWM clock reported as failed |
| int_clk | input | 1 | Internal PWM clock level |
| din | input | 4 | Direct inputs; bit 0 is also the external PWM clock |
| on_bits | input | 4 | Per-channel On bits |
| pass_bits | input | 4 | Per-channel direct-input permit bits |
| duty_codes | input | 28 | Packed 7-bit duty codes, channel x at bits 7x+6..7x |
| dly_codes | input | 12 | Packed 3-bit delay codes, channel x at bits 3x+2..3x |
| out_en | output | 4 | Channel output enables, registered |
| fault_qual | output | 4 | Channel fault-control qualifiers, registered |

## Verification
The period wrap that reloads the shadow codes can land on the same PWM edge as a change to the duty or delay codes. It can also land on the edge where a clock failure freezes the counter. The bench forces the first case by changing every code while the counter sits at position 127. The new values must show at position 0 and not before. The bench also sets failures and code changes at random positions. Each case is judged against a bench model that keeps its own position count and shadow copies, and every output is compared after each PWM edge.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;

   // How a channel's enable is produced
   typedef enum logic [1:0] {
      DRV_DIRECT = 2'd0,   // On bit or permitted direct input
      DRV_WAVE   = 2'd1,   // On bit gated by phased PWM wave
      DRV_STATIC = 2'd2    // PWM clock failed: On bit alone
   } drv_mode_e;

   function automatic drv_mode_e pick_mode(input logic pwm_on, input logic clk_bad);
      if (!pwm_on)
         return DRV_DIRECT;
      else if (clk_bad)
         return DRV_STATIC;
      else
         return DRV_WAVE;
   endfunction

endpackage

// File: rtl/pwm_tick_src.sv
module pwm_tick_src #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_sel,
   input  logic ext_lvl,
   input  logic int_lvl,
   output logic tick
);

   logic ext_s;
   logic int_s;
   logic sel_lvl;
   logic prev_lvl;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign ext_s = ext_lvl;
         assign int_s = int_lvl;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] ext_ff;
         logic [SYNC_STAGES-1:0] int_ff;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ext_ff <= '0;
               int_ff <= '0;
            end else begin
               ext_ff[0] <= ext_lvl;
               int_ff[0] <= int_lvl;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  ext_ff[i] <= ext_ff[i-1];
                  int_ff[i] <= int_ff[i-1];
               end
            end
         end
         assign ext_s = ext_ff[SYNC_STAGES-1];
         assign int_s = int_ff[SYNC_STAGES-1];
      end
   endgenerate

   assign sel_lvl = src_sel ? ext_s : int_s;

   always_ff @(posedge clk) begin
      if (!rst_n)
         prev_lvl <= 1'b0;
      else
         prev_lvl <= sel_lvl;
   end

   assign tick = sel_lvl & ~prev_lvl;

   // R7
   tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             hold,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);

   logic adv;

   assign adv  = tick & ~hold;
   assign wrap = adv & (cnt == {CNT_W{1'b1}});

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (adv)
         cnt <= cnt + CNT_W'(1);
   end

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> cnt == $past(cnt) + CNT_W'(1));

   // R8
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(cnt));

endmodule

// File: rtl/pwm_lane.sv
module pwm_lane
   import pwm_phase_pkg::*;
#(
   parameter int DUTY_W   = 7,
   parameter int DLY_W    = 3,
   parameter int DLY_STEP = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wrap,
   input  logic [DUTY_W-1:0] cnt,
   input  logic              pwm_en,
   input  logic              clk_bad,
   input  logic              on,
   input  logic              pass,
   input  logic              din,
   input  logic [DUTY_W-1:0] duty,
   input  logic [DLY_W-1:0]  dly,
   output logic              en_o,
   output logic              fq_o
);

   logic [DUTY_W-1:0] duty_sh;
   logic [DLY_W-1:0]  dly_sh;
   logic [DUTY_W-1:0] ofs;
   logic [DUTY_W-1:0] phase;
   logic              wave;
   logic              en_d;
   logic              fq_d;
   drv_mode_e         mode;

   // shadow codes reload only at period wrap
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         duty_sh <= '0;
         dly_sh  <= '0;
      end else if (wrap) begin
         duty_sh <= duty;
         dly_sh  <= dly;
      end
   end

   always_comb begin
      ofs   = DUTY_W'(int'(dly_sh) * DLY_STEP);
      phase = cnt - ofs;
      wave  = (phase <= duty_sh);
      mode  = pick_mode(pwm_en, clk_bad);
      unique case (mode)
         DRV_DIRECT: en_d = on | (din & pass);
         DRV_WAVE:   en_d = on & wave;
         DRV_STATIC: en_d = on;
         default:    en_d = 1'b0;
      endcase
      fq_d = on | (din & pass & ~pwm_en);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_o <= 1'b0;
         fq_o <= 1'b0;
      end else begin
         en_o <= en_d;
         fq_o <= fq_d;
      end
   end

   // R9
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> ($stable(duty_sh) && $stable(dly_sh)));

   // R3
   off_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_en && !clk_bad && !on) |=> !en_o);

   // R8
   fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_en && clk_bad) |=> en_o == $past(on));

   // R5
   direct_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwm_en && on) |=> en_o);

   // R6
   fq_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      on |=> fq_o);

endmodule

// File: rtl/pwm_phase_ctrl.sv
module pwm_phase_ctrl #(
   parameter int NCH         = 4,
   parameter int DUTY_W      = 7,
   parameter int DLY_W       = 3,
   parameter int DLY_STEP    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pwm_en,
   input  logic                  clk_sel,
   input  logic                  clk_fail,
   input  logic                  int_clk,
   input  logic [NCH-1:0]        din,
   input  logic [NCH-1:0]        on_bits,
   input  logic [NCH-1:0]        pass_bits,
   input  logic [NCH*DUTY_W-1:0] duty_codes,
   input  logic [NCH*DLY_W-1:0]  dly_codes,
   output logic [NCH-1:0]        out_en,
   output logic [NCH-1:0]        fault_qual
);

   localparam int PERIOD   = 2 ** DUTY_W;
   localparam int MAX_SHIFT = DLY_STEP * ((2 ** DLY_W) - 1);

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("pwm_phase_ctrl: NCH must be at least 1");
      end
      if (DLY_W < 1 || DUTY_W < 2) begin : g_bad_w
         $error("pwm_phase_ctrl: code widths too small");
      end
      if (MAX_SHIFT >= PERIOD) begin : g_bad_shift
         $error("pwm_phase_ctrl: largest delay must stay inside one period");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("pwm_phase_ctrl: SYNC_STAGES cannot be negative");
      end
   endgenerate

   logic              tick;
   logic              wrap;
   logic [DUTY_W-1:0] cnt;

   pwm_tick_src #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_sel(clk_sel),
      .ext_lvl(din[0]),
      .int_lvl(int_clk),
      .tick   (tick)
   );

   pwm_timebase #(
      .CNT_W(DUTY_W)
   ) u_tb (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .hold (clk_fail),
      .cnt  (cnt),
      .wrap (wrap)
   );

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_lane
         pwm_lane #(
            .DUTY_W  (DUTY_W),
            .DLY_W   (DLY_W),
            .DLY_STEP(DLY_STEP)
         ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .wrap   (wrap),
            .cnt    (cnt),
            .pwm_en (pwm_en),
            .clk_bad(clk_fail),
            .on     (on_bits[g]),
            .pass   (pass_bits[g]),
            .din    (din[g]),
            .duty   (duty_codes[g*DUTY_W +: DUTY_W]),
            .dly    (dly_codes[g*DLY_W +: DLY_W]),
            .en_o   (out_en[g]),
            .fq_o   (fault_qual[g])
         );
      end
   endgenerate

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (out_en == '0 && fault_qual == '0));

endmodule

// File: tb/pwm_phase_ctrl_test.sv
`timescale 1ns/1ps
module pwm_phase_ctrl_test;
   localparam int NCH = 4;
   localparam int DW  = 7;
   localparam int KW  = 3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            pwm_en = 1'b0;
   logic            clk_sel = 1'b0;
   logic            clk_fail = 1'b0;
   logic            int_clk = 1'b0;
   logic [NCH-1:0]  din = '0;
   logic [NCH-1:0]  on_bits = '0;
   logic [NCH-1:0]  pass_bits = '0;
   logic [NCH*DW-1:0] duty_codes = '0;
   logic [NCH*KW-1:0] dly_codes = '0;
   logic [NCH-1:0]  out_en;
   logic [NCH-1:0]  fault_qual;

   pwm_phase_ctrl uut (
      .clk(clk), .rst_n(rst_n), .pwm_en(pwm_en), .clk_sel(clk_sel),
      .clk_fail(clk_fail), .int_clk(int_clk), .din(din), .on_bits(on_bits),
      .pass_bits(pass_bits), .duty_codes(duty_codes), .dly_codes(dly_codes),
      .out_en(out_en), .fault_qual(fault_qual)
   );

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   // bench model of the timebase
   int pos = 0;
   int sh_duty[NCH];
   int sh_dly[NCH];

   task automatic check(input string req, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s pos=%0d actual=%0b expected=%0b", req, what, pos, act, exp);
      end
   endtask

   function automatic logic exp_en(input int ch);
      int ph;
      if (!pwm_en) return on_bits[ch] | (din[ch] & pass_bits[ch]);
      if (clk_fail) return on_bits[ch];
      ph = (((pos - 16 * sh_dly[ch]) % 128) + 128) % 128;
      return on_bits[ch] && (ph <= sh_duty[ch]);
   endfunction

   function automatic logic exp_fq(input int ch);
      return on_bits[ch] | (din[ch] & pass_bits[ch] & ~pwm_en);
   endfunction

   task automatic check_all(input string req);
      for (int ch = 0; ch < NCH; ch++) begin
         check(req, $sformatf("en[%0d]", ch), out_en[ch], exp_en(ch));
         check(req, $sformatf("fq[%0d]", ch), fault_qual[ch], exp_fq(ch));
      end
   endtask

   task automatic set_pin(input logic v);
      if (clk_sel) begin
         din[0] = v;
         int_clk = 1'($urandom);   // R7: unselected source wiggles
      end else begin
         int_clk = v;
      end
   endtask

   // one PWM clock edge, then model update and full check
   task automatic pwm_step(input string req);
      @(negedge clk);
      set_pin(1'b1);
      repeat (8) @(negedge clk);
      set_pin(1'b0);
      repeat (8) @(negedge clk);
      if (!clk_fail) begin
         if (pos == 127) begin
            pos = 0;
            for (int ch = 0; ch < NCH; ch++) begin
               sh_duty[ch] = int'(duty_codes[ch*DW +: DW]);
               sh_dly[ch]  = int'(dly_codes[ch*KW +: KW]);
            end
         end else begin
            pos++;
         end
      end
      check_all(req);
   endtask

   task automatic do_reset(input logic sel);
      @(negedge clk);
      rst_n = 1'b0;
      din[0] = 1'b0;
      int_clk = 1'b0;
      clk_sel = sel;
      repeat (4) @(negedge clk);
      // R1: outputs cleared during reset even with inputs asking for drive
      for (int ch = 0; ch < NCH; ch++) begin
         check("R1", $sformatf("rst en[%0d]", ch), out_en[ch], 1'b0);
         check("R1", $sformatf("rst fq[%0d]", ch), fault_qual[ch], 1'b0);
      end
      rst_n = 1'b1;
      pos = 0;
      for (int ch = 0; ch < NCH; ch++) begin
         sh_duty[ch] = 0;
         sh_dly[ch]  = 0;
      end
      repeat (3) @(negedge clk);
      check_all("R1 R9");
   endtask

   task automatic rand_codes();
      for (int ch = 0; ch < NCH; ch++) begin
         duty_codes[ch*DW +: DW] = DW'($urandom);
         dly_codes[ch*KW +: KW]  = KW'($urandom);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog (all requirements) actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int ch = 0; ch < NCH; ch++) begin
         sh_duty[ch] = 0;
         sh_dly[ch] = 0;
      end
      // R1 reset with every input asking for drive
      on_bits = 4'hF; pass_bits = 4'hF; din = 4'hE; pwm_en = 1'b1;
      duty_codes = {7'd10, 7'd127, 7'd63, 7'd0};
      dly_codes  = {3'd3, 3'd7, 3'd1, 3'd0};
      do_reset(1'b0);
      // R2 R4: first period zero codes, then the new codes
      repeat (128 + 256) pwm_step("R2 R4");
      // R3: On bits off for two channels
      on_bits = 4'b0101;
      repeat (128) pwm_step("R3");
      on_bits = 4'hF;
      // R9: code change exactly at position 127, the wrap edge
      while (pos != 127) pwm_step("R9");
      duty_codes = {7'd5, 7'd90, 7'd1, 7'd127};
      dly_codes  = {3'd7, 3'd0, 3'd5, 3'd2};
      repeat (130) pwm_step("R9");
      // R9: change mid period
      while (pos != 40) pwm_step("R9");
      rand_codes();
      repeat (140) pwm_step("R9");
      // R8: clock failure freezes and forces static drive
      on_bits = 4'b1001;
      clk_fail = 1'b1;
      repeat (40) pwm_step("R8");
      clk_fail = 1'b0;
      repeat (40) pwm_step("R8");
      // R8 at wrap edge
      while (pos != 127) pwm_step("R8");
      clk_fail = 1'b1;
      rand_codes();
      repeat (10) pwm_step("R8");
      clk_fail = 1'b0;
      repeat (20) pwm_step("R8 R9");
      // R5 R6: direct mode
      pwm_en = 1'b0;
      for (int i = 0; i < 64; i++) begin
         on_bits = 4'($urandom); pass_bits = 4'($urandom); din = 4'($urandom);
         pwm_step("R5 R6");
      end
      // R7: external clock from din[0], internal line toggled randomly
      pwm_en = 1'b1; on_bits = 4'hF;
      do_reset(1'b1);
      rand_codes();
      repeat (256) pwm_step("R7");
      // random mix on the internal clock
      do_reset(1'b0);
      for (int i = 0; i < 2560; i++) begin
         if ($urandom_range(31) == 0) rand_codes();
         if ($urandom_range(31) == 0) on_bits = 4'($urandom);
         if ($urandom_range(31) == 0) pass_bits = 4'($urandom);
         if ($urandom_range(15) == 0) din[3:1] = 3'($urandom);
         if ($urandom_range(127) == 0) pwm_en = ~pwm_en;
         if ($urandom_range(127) == 0) clk_fail = ~clk_fail;
         pwm_step("R2 R4 R5 R6 R8 R9");
      end
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule